// File: doc/BRIEF.md
# Zero-Page Window Bank Remapper

This block sits beside an 8-bit host bus with 16-bit addresses and turns each host address into a physical address in a large external RAM. It watches host writes to eight control bytes in page zero and keeps a copy of each one in its own registers. Two 16-bit bank numbers each pick one 8 KB bank for a fixed host window. Four 8-bit indices each move one 16-byte slice of upper page zero to one of 256 places.

The first bank number also moves a 16-byte scratch area in page zero along with its window. Each code bank therefore has a private scratch area. Every address that no register maps goes through unchanged, with the remap flag low, so the host's own memory serves it. The control bytes also go through unchanged, so the host memory holds their values and reads them back. Translation is combinational from the current register state, and a register update is used from the next host access on.

Top module: `zp_bank_remap`

## Requirements
- R1: After reset both bank numbers and all four indices are 0. Window accesses then go through unchanged, and a slice access maps with index 0.
- R2: A host write to $001C sets the low byte of bank A and a write to $001D sets its high byte. With bank A non-zero, an access to $6000..$7FFF raises `remap_hit` and gives `phys_addr` = {2'b01, bankA[15:0], addr[12:0]}.
- R3: Writes to $001E (low byte) and $001F (high byte) set bank B. With bank B non-zero, an access to $8000..$9FFF raises `remap_hit` and gives {2'b10, bankB[15:0], addr[12:0]}.
- R4: A bank number of 0 leaves its window, and for bank A also the scratch area, going through unchanged with `remap_hit` low.
- R5: With bank A non-zero, an access to $00B0..$00BF raises `remap_hit` and gives {2'b11, 1'b1, 8'h00, bankA[15:0], addr[3:0]}.
- R6: Bytes $0080..$0083 hold the indices of slices 0..3, where slice n covers $00C0+16n..$00CF+16n. An access to $00C0..$00FF always raises `remap_hit` and gives {2'b11, 1'b0, 14'h0, addr[5:4], index[7:0], addr[3:0]}.
- R7: Every other address goes through unchanged, including $0084..$00AF and the control bytes. For these `remap_hit` is low and `phys_addr` = {15'h0, addr}.
- R8: Only a cycle with `bus_valid` and `bus_we` both high and one of the eight control addresses changes a register. Reads, idle cycles and writes to other addresses change none.
- R9: A control write takes effect at the clock edge that ends its cycle, so the very next access translates with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| remap_hit | output | 1 | High when the address is remapped |
| phys_addr | output | 31 | Translated physical address |

## Verification
Two things can fall on back-to-back cycles: a register update and a translation that depends on it. The same bank A update also changes two regions at once, the 8 KB window and the scratch area. The bench provokes both with bank and index writes mixed among random accesses. These include directed sequences that write a control byte and then at once touch the window, the scratch area or the slice it governs. It also clears a bank back to zero in the middle of a run. Every access is judged against a bench model that applies each write only after the cycle that carries it.

// File: rtl/zp_bank_remap.sv
module zp_bank_remap (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        remap_hit,
  output logic [30:0] phys_addr
);
  localparam logic [1:0] TAG_PASS = 2'b00;
  localparam logic [1:0] TAG_WINA = 2'b01;
  localparam logic [1:0] TAG_WINB = 2'b10;
  localparam logic [1:0] TAG_ZP   = 2'b11;

  logic [15:0] bank_a, bank_b;
  logic [7:0]  idx [4];

  wire in_zp  = bus_addr[15:8] == 8'h00;
  wire wr     = bus_valid && bus_we && in_zp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_a <= '0;
      bank_b <= '0;
      for (int i = 0; i < 4; i++) idx[i] <= '0;
    end else if (wr) begin
      case (bus_addr[7:0])
        8'h1C: bank_a[7:0]  <= bus_wdata;
        8'h1D: bank_a[15:8] <= bus_wdata;
        8'h1E: bank_b[7:0]  <= bus_wdata;
        8'h1F: bank_b[15:8] <= bus_wdata;
        8'h80, 8'h81, 8'h82, 8'h83: idx[bus_addr[1:0]] <= bus_wdata;
        default: ;
      endcase
    end
  end

  wire win_a   = bus_addr[15:13] == 3'b011;
  wire win_b   = bus_addr[15:13] == 3'b100;
  wire scratch = in_zp && bus_addr[7:4] == 4'hB;
  wire slice   = in_zp && bus_addr[7:6] == 2'b11;
  wire a_on    = bank_a != 16'h0;
  wire b_on    = bank_b != 16'h0;

  always_comb begin
    remap_hit = 1'b1;
    if (win_a && a_on)
      phys_addr = {TAG_WINA, bank_a, bus_addr[12:0]};
    else if (win_b && b_on)
      phys_addr = {TAG_WINB, bank_b, bus_addr[12:0]};
    else if (scratch && a_on)
      phys_addr = {TAG_ZP, 1'b1, 8'h00, bank_a, bus_addr[3:0]};
    else if (slice)
      phys_addr = {TAG_ZP, 1'b0, 14'h0, bus_addr[5:4], idx[bus_addr[5:4]], bus_addr[3:0]};
    else begin
      remap_hit = 1'b0;
      phys_addr = {TAG_PASS, 13'h0, bus_addr};
    end
  end
endmodule

// File: rtl/zp_bank_remap_chk.sv
module zp_bank_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        remap_hit,
  input logic [30:0] phys_addr,
  input logic [15:0] bank_a,
  input logic [15:0] bank_b
);
  AST_BANKA_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'h001C) |=> bank_a[7:0] == $past(bus_wdata)); // R2
  AST_BANKB_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == 16'h001F) |=> bank_b[15:8] == $past(bus_wdata)); // R3
  AST_BANK_HOLD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_valid && bus_we)) |=> ($stable(bank_a) && $stable(bank_b))); // R8
  AST_ZERO_BANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:13] == 3'b011 && bank_a == 16'h0) |-> !remap_hit); // R4
  AST_SLICE_ALWAYS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:6] == 10'h003) |-> (remap_hit && phys_addr[30:28] == 3'b110)); // R6
  AST_FIXED_ZP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 16'h0084 && bus_addr <= 16'h00AF) |-> (!remap_hit && phys_addr == {15'h0, bus_addr})); // R7
  AST_PASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_hit |-> phys_addr == {15'h0, bus_addr}); // R7
endmodule

bind zp_bank_remap zp_bank_remap_chk u_chk (.*);

// File: tb/tb_zp_bank_remap.sv
`timescale 1ns/1ps
module tb_zp_bank_remap;
  logic clk = 1'b0, rst_n = 1'b0, bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        remap_hit;
  logic [30:0] phys_addr;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_a, m_b;
  logic [7:0]  m_idx [4];

  always #2.5 clk = ~clk;

  zp_bank_remap dut (.*);

  function automatic logic exp_hit(input logic [15:0] a);
    if (a[15:13] == 3'b011) return m_a != 0;
    if (a[15:13] == 3'b100) return m_b != 0;
    if (a[15:4] == 12'h00B) return m_a != 0;
    if (a[15:6] == 10'h003) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [30:0] exp_phys(input logic [15:0] a);
    if (a[15:13] == 3'b011 && m_a != 0) return {2'b01, m_a, a[12:0]};
    if (a[15:13] == 3'b100 && m_b != 0) return {2'b10, m_b, a[12:0]};
    if (a[15:4] == 12'h00B && m_a != 0) return {2'b11, 1'b1, 8'h00, m_a, a[3:0]};
    if (a[15:6] == 10'h003) return {2'b11, 1'b0, 14'h0, a[5:4], m_idx[a[5:4]], a[3:0]};
    return {15'h0, a};
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (a[15:13] == 3'b011) return (m_a != 0) ? "R2" : "R4";
    if (a[15:13] == 3'b100) return (m_b != 0) ? "R3" : "R4";
    if (a[15:4] == 12'h00B) return (m_a != 0) ? "R5" : "R4";
    if (a[15:6] == 10'h003) return "R6";
    return "R7";
  endfunction

  task automatic access(input logic [15:0] a, input logic v, input logic w,
                        input logic [7:0] d, input string tag);
    logic eh; logic [30:0] ep;
    @(negedge clk);
    bus_addr = a; bus_valid = v; bus_we = w; bus_wdata = d;
    #1;
    eh = exp_hit(a); ep = exp_phys(a);
    n_tests++;
    if (remap_hit !== eh || phys_addr !== ep) begin
      n_fail++;
      $display("FAIL %s/%s addr=%h hit=%b phys=%h expected hit=%b phys=%h",
               tag, req_of(a), a, remap_hit, phys_addr, eh, ep);
    end
    @(posedge clk);
    if (v && w && a[15:8] == 8'h00) begin
      case (a[7:0])
        8'h1C: m_a[7:0] = d;  8'h1D: m_a[15:8] = d;
        8'h1E: m_b[7:0] = d;  8'h1F: m_b[15:8] = d;
        8'h80, 8'h81, 8'h82, 8'h83: m_idx[a[1:0]] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    access(a, 1'b1, 1'b1, d, "R8");
  endtask

  function automatic logic [15:0] rand_addr();
    logic [15:0] r = 16'($urandom);
    case ($urandom % 6)
      0: return {3'b011, r[12:0]};
      1: return {3'b100, r[12:0]};
      2: return {12'h00B, r[3:0]};
      3: return {10'h003, r[5:0]};
      4: return 16'h0084 + 16'(r % 44);
      default: return r;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ctl [8] = '{16'h001C, 16'h001D, 16'h001E, 16'h001F,
                             16'h0080, 16'h0081, 16'h0082, 16'h0083};
    void'($urandom(32'd20240611));
    m_a = 0; m_b = 0;
    for (int i = 0; i < 4; i++) m_idx[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    access(16'h6000, 1, 0, 0, "R1");
    access(16'h9FFF, 1, 0, 0, "R1");
    access(16'h00B3, 1, 0, 0, "R1");
    access(16'h00D7, 1, 0, 0, "R1");
    // R2 / R9 back-to-back update then window and scratch
    wr(16'h001C, 8'h01);
    access(16'h6000, 1, 0, 0, "R9");
    access(16'h00BF, 1, 0, 0, "R5");
    wr(16'h001D, 8'hA5);
    access(16'h7FFF, 1, 1, 8'h33, "R2");
    // R3 max bank
    wr(16'h001E, 8'hFF); wr(16'h001F, 8'hFF);
    access(16'h9FFF, 1, 0, 0, "R3");
    access(16'h8000, 1, 0, 0, "R3");
    // R4 clearing bank A back to zero
    wr(16'h001C, 8'h00); access(16'h6123, 1, 0, 0, "R2");
    wr(16'h001D, 8'h00);
    access(16'h6123, 1, 0, 0, "R4");
    access(16'h00B0, 1, 0, 0, "R4");
    // R6 indices
    wr(16'h0083, 8'hAB); access(16'h00F3, 1, 0, 0, "R6");
    wr(16'h0080, 8'hFF); access(16'h00C0, 1, 0, 0, "R6");
    access(16'h00E9, 1, 0, 0, "R6");
    // R8 read, idle and invalid write leave indices unchanged
    access(16'h0080, 1, 0, 8'h11, "R8");
    access(16'h0080, 0, 1, 8'h22, "R8");
    access(16'h0083, 0, 0, 8'h44, "R8");
    access(16'h00C5, 1, 0, 0, "R8");
    access(16'h00F0, 1, 0, 0, "R8");
    // R7 fixed bytes and control bytes
    access(16'h0086, 1, 1, 8'h5A, "R7");
    access(16'h00AF, 1, 0, 0, "R7");
    access(16'h001C, 1, 0, 0, "R7");
    access(16'h0083, 1, 0, 0, "R7");
    access(16'h5FFF, 1, 0, 0, "R7");
    access(16'hA000, 1, 0, 0, "R7");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) begin
        logic [7:0] d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
        access(ctl[$urandom % 8], 1'($urandom % 8 != 0), 1'($urandom % 6 != 0), d, "R8");
      end else begin
        access(rand_addr(), 1'($urandom % 8 != 0), 1'($urandom % 2), 8'($urandom), "RND");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule